// File: doc/BRIEF.md
# Serial-Port Controller for an 8-bit Successive-Approximation Converter

This block is the digital side of a serially controlled analog-to-digital converter with a 16-code input selector. A host talks to it over four wires: an active-low chip select, a serial bit clock, a serial address line and a data line whose driver can be switched off. One byte-long transfer does two jobs at once. It shifts a 4-bit channel address into the block, and it shifts out the result of the conversion that came before. The host's serial lines need not match the block's system clock in any way. All three inputs pass through two-flop synchronisers, and their edges are detected on the system clock.

The chip select is filtered before the block acts on it. After the transfer, the block drives the sample-and-hold control and runs a fixed-length successive-approximation sequence. On each step the sequence presents a trial code to an external comparator. Codes 0 to 10 select external inputs and use the comparator. Code 11 selects an internal self-test level, which is compared inside the block. Codes 12 to 15 are reserved and always convert to zero. The host can restart the cycle by raising and lowering chip select during a conversion. This abandons the running conversion and leaves the last finished result unchanged.

Top module: `adc_serial_ctrl`

## Requirements
- R1: A low level on `cs_ni` is accepted only after it has been seen low, after synchronisation, on QUAL (3) consecutive system clocks. Serial-clock and address activity before that point does not count toward the transfer.
- R2: While chip select is not accepted, `dout_en_o` is 0. Serial-clock edges and address bits are ignored and do not disturb the next transfer.
- R3: When chip select is accepted, `dout_o` shows bit 7 of the last completed result before any serial-clock edge. After reset the result is 0.
- R4: The channel address is taken MSB first on the first four rising serial-clock edges. From the 4th falling edge, `chan_o` holds that address and `sample_o` is 1.
- R5: Result bits 6 down to 0 appear on `dout_o` in that order, one after each of the first seven falling serial-clock edges.
- R6: The 8th falling serial-clock edge ends sampling (`sample_o` goes to 0) and starts the conversion (`convert_o` goes to 1).
- R7: `convert_o` stays high for exactly 36 system clocks. In the clock where it falls, `done_o` is 1 for one cycle and the result register takes the new code.
- R8: If chip select is accepted again during a conversion, that conversion is abandoned: `convert_o` falls with no `done_o`, and the next readout returns the last completed result.
- R9: Codes 0 to 10 convert using `cmp_i`, which means the trial code is at or below the input. Code 11 converts the internal level SELFTEST_CODE (128) without using `cmp_i`. Codes 12 to 15 always convert to 0.
- R10: An input at or above full scale, where `cmp_i` is always 1, converts to 255. An input below zero, where `cmp_i` is always 0, converts to 0.
- R11: If chip select stays low, bit 7 of the new result is on `dout_o` one clock after `done_o`, and the next transfer can follow without toggling chip select.
- R12: Serial-clock edges during a conversion are ignored. They do not shorten the conversion or shift the output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cs_ni | input | 1 | Active-low chip select, asynchronous |
| ioclk_i | input | 1 | Serial bit clock, asynchronous |
| addr_i | input | 1 | Serial channel address, MSB first |
| dout_o | output | 1 | Serial result bit |
| dout_en_o | output | 1 | Output driver enable (0 means high impedance) |
| chan_o | output | 4 | Channel code to the analog selector |
| sample_o | output | 1 | Sample switch closed |
| convert_o | output | 1 | Conversion running (input held) |
| trial_o | output | 8 | Trial code to the comparator DAC |
| cmp_i | input | 1 | Comparator: input is at or above the trial code |
| done_o | output | 1 | One-cycle pulse when a result is written |

## Verification
The bench sends a serial-clock pulse inside the chip-select filter window, with the address line inverted. A filter that is too short would count that pulse, shift the address by one bit and start the conversion one edge early. It toggles the serial clock while chip select is high and again while a conversion runs. A port that does not gate those edges would show a misaligned readout or a conversion that is not 36 clocks long. It abandons a conversion with a chip-select cycle and expects the older result on readback; a design that writes partial results would return the new code. It also drives `cmp_i` high on codes 11 to 15, so a design that consults the comparator on the self-test or reserved codes reads back 255 instead of 128 or 0.

// File: rtl/adc_ser_pkg.sv
package adc_ser_pkg;
  localparam int ADDR_W = 4;

  typedef enum logic [1:0] {
    SRC_EXT  = 2'd0,
    SRC_SELF = 2'd1,
    SRC_NONE = 2'd2
  } src_e;

  function automatic src_e chan_src(input logic [ADDR_W-1:0] ch, input int n_ext);
    if (int'(ch) < n_ext) return SRC_EXT;
    if (int'(ch) == n_ext) return SRC_SELF;
    return SRC_NONE;
  endfunction
endpackage

// File: rtl/adc_port_sync.sv
module adc_port_sync #(
  parameter int          N       = 3,
  parameter logic [N-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] d_i,
  output logic [N-1:0] q_o
);
  for (genvar g = 0; g < N; g++) begin : g_line
    logic s1_q, s2_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        s1_q <= RST_VAL[g];
        s2_q <= RST_VAL[g];
      end else begin
        s1_q <= d_i[g];
        s2_q <= s1_q;
      end
    end
    assign q_o[g] = s2_q;
  end
endmodule

// File: rtl/adc_cs_qual.sv
module adc_cs_qual #(
  parameter int QUAL = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cs_n_i,
  output logic act_o,
  output logic start_o,
  output logic end_o
);
  localparam int QW = $clog2(QUAL + 1);

  logic [QW-1:0] qcnt_q;
  logic          act_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      qcnt_q <= '0;
      act_q  <= 1'b0;
    end else if (cs_n_i) begin
      qcnt_q <= '0;
      act_q  <= 1'b0;
    end else if (!act_q) begin
      if (qcnt_q == QW'(QUAL - 1)) act_q <= 1'b1;
      else qcnt_q <= qcnt_q + 1'b1;
    end
  end

  assign act_o   = act_q;
  assign start_o = !cs_n_i && !act_q && (qcnt_q == QW'(QUAL - 1));
  assign end_o   = cs_n_i && act_q;

  // R1: acceptance needs a run of low samples
  p_cs_filter_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(act_q) |-> (!$past(cs_n_i, 1) && !$past(cs_n_i, 2)));
endmodule

// File: rtl/adc_serial_io.sv
module adc_serial_io #(
  parameter int RES_W  = 8,
  parameter int ADDR_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_act_i,
  input  logic              cs_start_i,
  input  logic              cs_end_i,
  input  logic              io_i,
  input  logic              addr_i,
  input  logic              busy_i,
  input  logic              done_i,
  input  logic [RES_W-1:0]  result_i,
  output logic              dout_o,
  output logic [ADDR_W-1:0] chan_o,
  output logic              sample_o,
  output logic              conv_start_o
);
  localparam int FW = $clog2(RES_W);
  localparam int RW = $clog2(ADDR_W + 1);

  logic              io_prev_q;
  logic [RES_W-1:0]  shreg_q;
  logic [ADDR_W-1:0] addr_sh_q, chan_q;
  logic [FW-1:0]     fcnt_q;
  logic [RW-1:0]     rcnt_q;
  logic              sample_q;
  logic              io_ok, io_rise, io_fall, last_fall;

  assign io_rise   = io_i && !io_prev_q;
  assign io_fall   = !io_i && io_prev_q;
  // edges count only with an accepted select and an idle converter
  assign io_ok     = cs_act_i && !busy_i && !cs_start_i && !cs_end_i && !done_i;
  assign last_fall = io_ok && io_fall && (fcnt_q == FW'(RES_W - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) io_prev_q <= 1'b0;
    else         io_prev_q <= io_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shreg_q   <= '0;
      addr_sh_q <= '0;
      chan_q    <= '0;
      fcnt_q    <= '0;
      rcnt_q    <= '0;
      sample_q  <= 1'b0;
    end else if (cs_start_i || (done_i && cs_act_i)) begin
      shreg_q  <= result_i;
      fcnt_q   <= '0;
      rcnt_q   <= '0;
      sample_q <= 1'b0;
    end else if (cs_end_i) begin
      fcnt_q   <= '0;
      rcnt_q   <= '0;
      sample_q <= 1'b0;
    end else if (io_ok) begin
      if (io_rise && (rcnt_q < RW'(ADDR_W))) begin
        addr_sh_q <= {addr_sh_q[ADDR_W-2:0], addr_i};
        rcnt_q    <= rcnt_q + 1'b1;
      end
      if (io_fall) begin
        if (last_fall) begin
          fcnt_q   <= '0;
          rcnt_q   <= '0;
          sample_q <= 1'b0;
        end else begin
          shreg_q <= {shreg_q[RES_W-2:0], 1'b0};
          fcnt_q  <= fcnt_q + 1'b1;
          if (fcnt_q == FW'(ADDR_W - 1)) begin
            chan_q   <= addr_sh_q;
            sample_q <= 1'b1;
          end
        end
      end
    end
  end

  assign dout_o       = shreg_q[RES_W-1];
  assign chan_o       = chan_q;
  assign sample_o     = sample_q;
  assign conv_start_o = last_fall;

  // R2: no transfer progress without an accepted select
  p_idle_counters_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cs_act_i |-> (fcnt_q == '0 && rcnt_q == '0));
  // R12: output shifter frozen while converting
  p_no_shift_busy_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && !cs_start_i) |=> $stable(shreg_q));
endmodule

// File: rtl/adc_sar_seq.sv
module adc_sar_seq
  import adc_ser_pkg::*;
#(
  parameter int RES_W         = 8,
  parameter int CONV_CYCLES   = 36,
  parameter int N_EXT         = 11,
  parameter int SELFTEST_CODE = 128
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              abort_i,
  input  logic [ADDR_W-1:0] chan_i,
  input  logic              cmp_i,
  output logic [RES_W-1:0]  trial_o,
  output logic              busy_o,
  output logic              done_o,
  output logic [RES_W-1:0]  result_o
);
  localparam int CW = $clog2(CONV_CYCLES + 1);

  logic [CW-1:0]    ccnt_q, len_q;
  logic [RES_W-1:0] sar_q, result_q, mask, trial;
  logic             busy_q, done_q, cmp_eff, in_step;
  src_e             src;

  assign in_step = busy_q && (int'(ccnt_q) < RES_W);

  always_comb begin
    mask = '0;
    if (in_step) mask[RES_W-1-int'(ccnt_q)] = 1'b1;
  end

  assign trial = sar_q | mask;
  assign src   = chan_src(chan_i, N_EXT);

  always_comb begin
    unique case (src)
      SRC_EXT:  cmp_eff = cmp_i;
      SRC_SELF: cmp_eff = (RES_W'(SELFTEST_CODE) >= trial);
      default:  cmp_eff = 1'b0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ccnt_q   <= '0;
      sar_q    <= '0;
      result_q <= '0;
      busy_q   <= 1'b0;
      done_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (abort_i) begin
        busy_q <= 1'b0;
      end else if (start_i) begin
        busy_q <= 1'b1;
        ccnt_q <= '0;
        sar_q  <= '0;
      end else if (busy_q) begin
        if (in_step && cmp_eff) sar_q <= trial;
        if (ccnt_q == CW'(CONV_CYCLES - 1)) begin
          busy_q   <= 1'b0;
          done_q   <= 1'b1;
          result_q <= sar_q;
        end else begin
          ccnt_q <= ccnt_q + 1'b1;
        end
      end
    end
  end

  assign trial_o  = trial;
  assign busy_o   = busy_q;
  assign done_o   = done_q;
  assign result_o = result_q;

  // independent run-length counter for the conversion window
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     len_q <= '0;
    else if (busy_q) len_q <= len_q + 1'b1;
    else             len_q <= '0;
  end

  p_conv_len_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |-> (len_q == CW'(CONV_CYCLES)));
  p_done_pulse_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |=> !done_q);
  p_abort_keeps_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_i |=> ($stable(result_q) && !done_q));
  p_reserved_zero_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_q && src == SRC_NONE) |-> (result_q == '0));
endmodule

// File: rtl/adc_serial_ctrl.sv
module adc_serial_ctrl
  import adc_ser_pkg::*;
#(
  parameter int RES_W         = 8,
  parameter int CONV_CYCLES   = 36,
  parameter int QUAL          = 3,
  parameter int N_EXT         = 11,
  parameter int SELFTEST_CODE = 128
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_ni,
  input  logic              ioclk_i,
  input  logic              addr_i,
  output logic              dout_o,
  output logic              dout_en_o,
  output logic [ADDR_W-1:0] chan_o,
  output logic              sample_o,
  output logic              convert_o,
  output logic [RES_W-1:0]  trial_o,
  input  logic              cmp_i,
  output logic              done_o
);
  logic [2:0]       sync_q;
  logic             cs_act, cs_start, cs_end, conv_start, busy, done;
  logic [RES_W-1:0] result;

  adc_port_sync #(.N(3), .RST_VAL(3'b001)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    ({addr_i, ioclk_i, cs_ni}),
    .q_o    (sync_q)
  );

  adc_cs_qual #(.QUAL(QUAL)) u_qual (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .cs_n_i  (sync_q[0]),
    .act_o   (cs_act),
    .start_o (cs_start),
    .end_o   (cs_end)
  );

  adc_serial_io #(.RES_W(RES_W), .ADDR_W(ADDR_W)) u_io (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .cs_act_i     (cs_act),
    .cs_start_i   (cs_start),
    .cs_end_i     (cs_end),
    .io_i         (sync_q[1]),
    .addr_i       (sync_q[2]),
    .busy_i       (busy),
    .done_i       (done),
    .result_i     (result),
    .dout_o       (dout_o),
    .chan_o       (chan_o),
    .sample_o     (sample_o),
    .conv_start_o (conv_start)
  );

  adc_sar_seq #(
    .RES_W(RES_W), .CONV_CYCLES(CONV_CYCLES),
    .N_EXT(N_EXT), .SELFTEST_CODE(SELFTEST_CODE)
  ) u_sar (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (conv_start),
    .abort_i  (cs_start),
    .chan_i   (chan_o),
    .cmp_i    (cmp_i),
    .trial_o  (trial_o),
    .busy_o   (busy),
    .done_o   (done),
    .result_o (result)
  );

  assign dout_en_o = cs_act;
  assign convert_o = busy;
  assign done_o    = done;

  // R6: conversion only follows a sampling phase
  p_conv_after_sample_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy) |-> $past(sample_o));
  // R4: sampling and conversion never overlap
  p_phase_excl_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(sample_o && busy));
endmodule

// File: tb/adc_serial_ctrl_tb.sv
module adc_serial_ctrl_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cs_n = 1'b1, ioclk = 1'b0, addr = 1'b0;
  logic       dout, dout_en, sample, convert, done, cmp;
  logic [3:0] chan;
  logic [7:0] trial;

  int checks = 0;
  int errors = 0;
  int analog [0:10];
  logic [7:0] exp_prev = 8'd0;

  always #2 clk = ~clk;

  adc_serial_ctrl u_dut (
    .clk_i(clk), .rst_ni(rst_n), .cs_ni(cs_n), .ioclk_i(ioclk), .addr_i(addr),
    .dout_o(dout), .dout_en_o(dout_en), .chan_o(chan), .sample_o(sample),
    .convert_o(convert), .trial_o(trial), .cmp_i(cmp), .done_o(done)
  );

  function automatic int clamp8(int v);
    if (v < 0) return 0;
    if (v > 255) return 255;
    return v;
  endfunction

  // comparator model; codes 11..15 answer 1 so any use of it shows up
  assign cmp = (chan <= 4'd10) ? (clamp8(analog[chan]) >= int'(trial)) : 1'b1;

  function automatic logic [7:0] code_of(logic [3:0] ch);
    if (ch <= 4'd10) return 8'(clamp8(analog[ch]));
    if (ch == 4'd11) return 8'd128;
    return 8'd0;
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic cs_select(bit glitch, logic [3:0] a);
    cs_n = 1'b0;
    if (glitch) begin
      step(1); ioclk = 1'b1; addr = ~a[3];
      step(1); ioclk = 1'b0;
      step(8);
    end else step(8);
  endtask

  task automatic cs_release();
    cs_n = 1'b1;
    step(6);
    chk(dout_en == 1'b0, "R2 driver off", int'(dout_en), 0);
  endtask

  task automatic xfer(logic [3:0] a, output logic [7:0] rd);
    rd[7] = dout;
    for (int i = 0; i < 8; i++) begin
      addr = (i < 4) ? a[3-i] : 1'($urandom);
      step(2); ioclk = 1'b1;
      step(4); ioclk = 1'b0;
      if (i < 7) begin
        step(4);
        rd[6-i] = dout;
        if (i == 3) begin
          chk(sample == 1'b1, "R4 sample", int'(sample), 1);
          chk(chan == a, "R4 channel", int'(chan), int'(a));
        end
      end
    end
  endtask

  task automatic wait_conv(bit noisy);
    int w = 0;
    int len = 0;
    while (!convert && w < 20) begin step(1); w++; end
    chk(convert == 1'b1, "R6 conversion start", int'(convert), 1);
    chk(sample == 1'b0, "R6 sampling ended", int'(sample), 0);
    while (convert && len < 100) begin
      if (noisy) ioclk = (len < 24) && ((len % 8) < 4);
      step(1); len++;
    end
    chk(len == 36, noisy ? "R12 length under noise" : "R7 length", len, 36);
    chk(done == 1'b1, "R7 done pulse", int'(done), 1);
    step(1);
    chk(done == 1'b0, "R7 done single", int'(done), 0);
  endtask

  task automatic run_conv(logic [3:0] a, bit glitch, string req);
    logic [7:0] rd;
    logic [7:0] exp_cur;
    cs_select(glitch, a);
    chk(dout_en == 1'b1, "R3 driver on", int'(dout_en), 1);
    chk(dout == exp_prev[7], "R3 msb first", int'(dout), int'(exp_prev[7]));
    exp_cur = code_of(a);
    xfer(a, rd);
    chk(rd == exp_prev, req, int'(rd), int'(exp_prev));
    wait_conv(1'b0);
    exp_prev = exp_cur;
    cs_release();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL R7 watchdog actual=hung expected=finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] rd;
    void'($urandom(32'h5eed));
    for (int i = 0; i < 11; i++) analog[i] = 17 * i;
    step(4);
    chk(dout_en == 1'b0 && convert == 1'b0 && sample == 1'b0 && done == 1'b0,
        "R2 reset state", int'({dout_en, convert, sample, done}), 0);
    rst_n = 1'b1;
    step(3);

    analog[3] = 8'hA5;
    run_conv(4'd3, 1'b0, "R5 readout after reset");

    // R2: serial activity with select high is ignored
    for (int i = 0; i < 3; i++) begin
      addr = 1'b1; ioclk = 1'b1; step(4);
      chk(dout_en == 1'b0, "R2 hi-z while idle", int'(dout_en), 0);
      ioclk = 1'b0; step(4);
    end
    analog[5] = 8'h5A;
    run_conv(4'd5, 1'b0, "R2 readout after idle clocks");

    // R1: pulse inside the filter window is not counted
    analog[7] = 8'hC3;
    run_conv(4'd7, 1'b1, "R5 readout");
    run_conv(4'd11, 1'b0, "R1 readout after filtered glitch");

    // R9 / R10: self test, reserved and saturating codes
    run_conv(4'd13, 1'b0, "R9 self-test code");
    analog[0] = 300;
    run_conv(4'd0, 1'b0, "R9 reserved code");
    analog[1] = -7;
    run_conv(4'd1, 1'b0, "R10 above full scale");
    run_conv(4'd15, 1'b0, "R10 below zero");

    // R8: abandon a running conversion with a select cycle
    begin
      logic [7:0] keep;
      int w = 0;
      run_conv(4'd2, 1'b0, "R9 reserved code 15");
      keep = exp_prev;
      analog[4] = 8'h3C;
      cs_select(1'b0, 4'd4);
      xfer(4'd4, rd);
      chk(rd == keep, "R5 readout", int'(rd), int'(keep));
      while (!convert && w < 20) begin step(1); w++; end
      step(6);
      cs_n = 1'b1; step(4);
      cs_n = 1'b0; step(8);
      chk(convert == 1'b0, "R8 conversion abandoned", int'(convert), 0);
      chk(dout == keep[7], "R8 msb of kept result", int'(dout), int'(keep[7]));
      analog[9] = 8'h81;
      xfer(4'd9, rd);
      chk(rd == keep, "R8 kept result", int'(rd), int'(keep));
      wait_conv(1'b0);
      exp_prev = 8'h81;
      cs_release();
    end

    // R11 / R12: select held low, serial noise during conversion
    begin
      analog[6] = 8'h96;
      cs_select(1'b0, 4'd6);
      xfer(4'd6, rd);
      chk(rd == exp_prev, "R5 readout", int'(rd), int'(exp_prev));
      wait_conv(1'b1);
      chk(dout == 1'b1, "R11 new msb without select toggle", int'(dout), 1);
      analog[8] = 8'h2B;
      xfer(4'd8, rd);
      chk(rd == 8'h96, "R12 readout after noisy conversion", int'(rd), 8'h96);
      wait_conv(1'b0);
      exp_prev = 8'h2B;
      cs_release();
    end

    // random mix
    for (int n = 0; n < 16; n++) begin
      logic [3:0] a;
      a = 4'($urandom_range(0, 15));
      for (int i = 0; i < 11; i++) analog[i] = int'($urandom_range(0, 295)) - 20;
      run_conv(a, 1'($urandom_range(0, 1)), "R9 random readout");
    end
    run_conv(4'd0, 1'b0, "R5 final readout");

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule